// File: doc/BRIEF.md
# Modem Control Register Access Sequencer

This block runs one complete access to a power-line modem's control register over the modem's own clocked serial link. The modem supplies the bit clock. The block supplies the register-select and direction lines and a transmit data line. It takes the receive data line back. A single-cycle start command begins either a read or a write. The block drives both selects and shifts the bits itself. It signals completion with a one-cycle `done` pulse and an error flag.

A read collects 48 bits as six bytes. The block then decides whether the modem has a 24-bit or a 48-bit register. Bytes 3 to 5 that are all zero or all one mark a 24-bit part, and then the real contents are in bytes 0 to 2. The result is 56 bits wide. It always carries the significant low 24 bits in the same place and ends with an information byte that tells which width was found. A write shifts out six bytes, most significant bit first. Both accesses keep a local copy of the low 24 register bits.

Each access begins with a bounded wait for the modem clock to be low. Once the selects are driven, the rest of the access is bounded by an overall timeout. If that timeout expires, the block aborts with an error and releases the selects.

States: `ST_IDLE` (selects released), `ST_WAIT` (waiting for the modem clock to be low, or for the wait bound), `ST_READ` (sampling on rising modem-clock edges), `ST_WRITE` (shifting on falling modem-clock edges), `ST_RESOLVE` (one cycle: commit the result) and `ST_ABORT` (one cycle: flag the error).

Transitions:
- IDLE→WAIT on a start.
- WAIT→READ or WAIT→WRITE when the clock is seen low or the wait bound expires.
- READ→RESOLVE on the 48th rising edge.
- WRITE→RESOLVE on the 48th falling edge.
- READ→ABORT or WRITE→ABORT when the overall timeout expires.
- RESOLVE→IDLE and ABORT→IDLE always.

Top module: `ctlreg_seq`

## Requirements
- R1: After reset and whenever no access is running, `sel_reg`=0, `dir_rx`=1, `mtx`=0, `busy`=0 and `done`=0. After reset, `err`, `rd_result` and `low_copy` are all zero.
- R2: A pulse on `start_rd` or `start_wr` while idle begins an access. If both are high in the same cycle, the read is taken. A start pulse while `busy`=1 is ignored and produces no extra `done`.
- R3: After a start, the selects stay released until the synchronized modem clock is seen low, or until `WAIT_CYC` cycles have passed. The access then proceeds in either case.
- R4: A read drives `sel_reg`=1 and `dir_rx`=1. It samples `mrx` at 48 rising edges of `mclk`. The first bit is the most significant bit of byte 0, and raw bit 47 is that first bit.
- R5: If raw bytes 3..5 (raw[23:0]) are all 0x00 or all 0xFF, the result is {raw[23:0], raw[47:24], 8'h00}, so byte 0 of the result is raw byte 3 and the last byte is 0x00.
- R6: Otherwise the result is {raw[47:0], 8'hFF}.
- R7: A write drives `sel_reg`=1 and `dir_rx`=0. It presents `wr_data[47]` on `mtx` when the selects are asserted and moves to the next lower bit at each falling edge of `mclk`. The 48th falling edge ends the write, so the modem sees all 48 bits at its rising edges.
- R8: `low_copy` is loaded with `wr_data[23:0]` when a write starts. When a read succeeds, it takes the register's low 24 bits: raw[47:24] for a 24-bit register and raw[23:0] for a 48-bit one. This always equals `rd_result[31:8]`.
- R9: An access not finished within `TOTAL_CYC` cycles after the selects are asserted is aborted. It ends with `done`=1 and `err`=1, and a read abort leaves `rd_result` and `low_copy` unchanged.
- R10: `done` is a one-cycle pulse. It rises in the same cycle that `busy` and `sel_reg` fall. On success `err` is 0, and `err` keeps its value until the next `done`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_rd | input | 1 | One-cycle request for a register read |
| start_wr | input | 1 | One-cycle request for a register write |
| wr_data | input | 48 | Register image to write, byte 0 in bits 47:40 |
| mclk | input | 1 | Bit clock supplied by the modem |
| mrx | input | 1 | Serial data from the modem |
| mtx | output | 1 | Serial data to the modem |
| sel_reg | output | 1 | Register-access select, high during an access |
| dir_rx | output | 1 | Direction select: 1 receive, 0 transmit |
| busy | output | 1 | An access is in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Outcome of the last access: 1 means timeout |
| rd_result | output | 56 | Reordered read result ending with the information byte |
| low_copy | output | 24 | Local copy of the register's low 24 bits |

## Verification
The assertions rely on three properties of the inputs:
- Start requests are single-cycle pulses.
- The modem clock toggles far more slowly than the synchronizer latency.
- The receive data is stable around each rising modem-clock edge.

The stimulus meets these by generating the modem clock with a ten-cycle half period and changing `mrx` only on falling modem-clock edges. It also freezes the clock high only when it exercises the wait bound and the overall timeout. The bounded-busy check sizes its window from the two timeout parameters, so it holds only while the bench keeps a stalled access below that sum.

// File: rtl/ctlreg_pkg.sv
package ctlreg_pkg;

    localparam int BYTE_W    = 8;
    localparam int REG_BYTES = 6;
    localparam int FRAME_W   = REG_BYTES * BYTE_W;
    localparam int HALF_W    = FRAME_W / 2;
    localparam int RES_W     = FRAME_W + BYTE_W;
    localparam int BITCNT_W  = $clog2(FRAME_W);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT,
        ST_READ,
        ST_WRITE,
        ST_RESOLVE,
        ST_ABORT
    } state_t;

endpackage

// File: rtl/ctlreg_sync.sv
module ctlreg_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    logic [W-1:0] chain [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[s] <= '0;
                    else        chain[s] <= din;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[s] <= '0;
                    else        chain[s] <= chain[s-1];
                end
            end
        end
    endgenerate

    assign dout = chain[STAGES-1];

endmodule

// File: rtl/ctlreg_timer.sv
module ctlreg_timer #(
    parameter int LIMIT = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic run,
    output logic expired
);

    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LIM = CW'(LIMIT);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear) begin
            cnt_q <= '0;
        end else if (run && cnt_q != LIM) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign expired = (cnt_q == LIM);

endmodule

// File: rtl/ctlreg_shreg.sv
module ctlreg_shreg #(
    parameter int W = 48
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         shift,
    input  logic         sin,
    output logic [W-1:0] q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else if (load) begin
            q <= load_val;
        end else if (shift) begin
            q <= {q[W-2:0], sin};
        end
    end

endmodule

// File: rtl/ctlreg_reorder.sv
module ctlreg_reorder #(
    parameter int HALF_W = 24,
    parameter int INFO_W = 8
) (
    input  logic [2*HALF_W-1:0]        raw,
    output logic [2*HALF_W+INFO_W-1:0] result,
    output logic [HALF_W-1:0]          low
);

    logic [HALF_W-1:0] upper_half;
    logic [HALF_W-1:0] lower_half;
    logic              narrow;

    assign upper_half = raw[2*HALF_W-1:HALF_W];
    assign lower_half = raw[HALF_W-1:0];

    // a part with a half-width register pads the second half with one constant level
    assign narrow = (lower_half == '0) || (lower_half == '1);

    always_comb begin
        if (narrow) begin
            result = {lower_half, upper_half, {INFO_W{1'b0}}};
            low    = upper_half;
        end else begin
            result = {upper_half, lower_half, {INFO_W{1'b1}}};
            low    = lower_half;
        end
    end

endmodule

// File: rtl/ctlreg_seq.sv
module ctlreg_seq
    import ctlreg_pkg::*;
#(
    parameter int WAIT_CYC    = 200000,
    parameter int TOTAL_CYC   = 10000000,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_rd,
    input  logic               start_wr,
    input  logic [FRAME_W-1:0] wr_data,
    input  logic               mclk,
    input  logic               mrx,
    output logic               mtx,
    output logic               sel_reg,
    output logic               dir_rx,
    output logic               busy,
    output logic               done,
    output logic               err,
    output logic [RES_W-1:0]   rd_result,
    output logic [HALF_W-1:0]  low_copy
);

    localparam logic [BITCNT_W-1:0] LAST_BIT = BITCNT_W'(FRAME_W - 1);

    state_t state_q, state_d;

    logic [1:0]          sync_out;
    logic                mclk_s, mrx_s, mclk_prev;
    logic                clk_rise, clk_fall;
    logic                wait_exp, total_exp;
    logic                op_rd_q;
    logic [BITCNT_W-1:0] bit_cnt_q;
    logic                last_bit;
    logic                sh_load, sh_shift, sh_in;
    logic [FRAME_W-1:0]  sh_q;
    logic [RES_W-1:0]    reord_res;
    logic [HALF_W-1:0]   reord_low;
    logic                take_rd, take_wr;

    // modem clock and data enter through the same synchronizer so they stay aligned
    ctlreg_sync #(
        .W      (2),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({mclk, mrx}),
        .dout  (sync_out)
    );

    assign mclk_s = sync_out[1];
    assign mrx_s  = sync_out[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mclk_prev <= 1'b0;
        else        mclk_prev <= mclk_s;
    end

    assign clk_rise = mclk_s & ~mclk_prev;
    assign clk_fall = ~mclk_s & mclk_prev;

    ctlreg_timer #(
        .LIMIT (WAIT_CYC)
    ) u_wait_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (state_q != ST_WAIT),
        .run     (state_q == ST_WAIT),
        .expired (wait_exp)
    );

    ctlreg_timer #(
        .LIMIT (TOTAL_CYC)
    ) u_total_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   ((state_q == ST_IDLE) || (state_q == ST_WAIT)),
        .run     ((state_q == ST_READ) || (state_q == ST_WRITE)),
        .expired (total_exp)
    );

    assign take_rd  = (state_q == ST_IDLE) && start_rd;
    assign take_wr  = (state_q == ST_IDLE) && start_wr && !start_rd;
    assign last_bit = (bit_cnt_q == LAST_BIT);

    // one shift register serves both directions: it collects on a read and drains on a write
    assign sh_load  = take_wr;
    assign sh_shift = ((state_q == ST_READ) && clk_rise) ||
                      ((state_q == ST_WRITE) && clk_fall);
    assign sh_in    = (state_q == ST_READ) ? mrx_s : 1'b0;

    ctlreg_shreg #(
        .W (FRAME_W)
    ) u_shreg (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (sh_load),
        .load_val (wr_data),
        .shift    (sh_shift),
        .sin      (sh_in),
        .q        (sh_q)
    );

    ctlreg_reorder #(
        .HALF_W (HALF_W),
        .INFO_W (BYTE_W)
    ) u_reorder (
        .raw    (sh_q),
        .result (reord_res),
        .low    (reord_low)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt_q <= '0;
        end else if (state_q == ST_WAIT) begin
            bit_cnt_q <= '0;
        end else if (sh_shift) begin
            bit_cnt_q <= bit_cnt_q + 1'b1;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state: a completing edge takes precedence over a timeout in the same cycle
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_rd || start_wr) state_d = ST_WAIT;
            end
            ST_WAIT: begin
                if (!mclk_s || wait_exp) state_d = op_rd_q ? ST_READ : ST_WRITE;
            end
            ST_READ: begin
                if (clk_rise && last_bit) state_d = ST_RESOLVE;
                else if (total_exp)       state_d = ST_ABORT;
            end
            ST_WRITE: begin
                if (clk_fall && last_bit) state_d = ST_RESOLVE;
                else if (total_exp)       state_d = ST_ABORT;
            end
            ST_RESOLVE: state_d = ST_IDLE;
            ST_ABORT:   state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // registered outputs and operation record
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_rd_q   <= 1'b0;
            done      <= 1'b0;
            err       <= 1'b0;
            rd_result <= '0;
            low_copy  <= '0;
        end else begin
            done <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (take_rd) begin
                        op_rd_q <= 1'b1;
                    end else if (take_wr) begin
                        op_rd_q  <= 1'b0;
                        low_copy <= wr_data[HALF_W-1:0];
                    end
                end
                ST_RESOLVE: begin
                    done <= 1'b1;
                    err  <= 1'b0;
                    if (op_rd_q) begin
                        rd_result <= reord_res;
                        low_copy  <= reord_low;
                    end
                end
                ST_ABORT: begin
                    done <= 1'b1;
                    err  <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    // line drive decoded from state
    always_comb begin
        busy    = (state_q != ST_IDLE);
        sel_reg = (state_q == ST_READ) || (state_q == ST_WRITE) ||
                  (state_q == ST_RESOLVE) || (state_q == ST_ABORT);
        dir_rx  = !(sel_reg && !op_rd_q);
        mtx     = (state_q == ST_WRITE) ? sh_q[FRAME_W-1] : 1'b0;
    end

endmodule

// File: rtl/ctlreg_seq_chk.sv
module ctlreg_seq_chk #(
    parameter int WAIT_CYC  = 200000,
    parameter int TOTAL_CYC = 10000000
) (
    input logic        clk,
    input logic        rst_n,
    input logic        start_rd,
    input logic        start_wr,
    input logic [47:0] wr_data,
    input logic        mtx,
    input logic        sel_reg,
    input logic        dir_rx,
    input logic        busy,
    input logic        done,
    input logic        err,
    input logic [55:0] rd_result,
    input logic [23:0] low_copy
);

    localparam logic [31:0] BOUND = 32'(WAIT_CYC + TOTAL_CYC + 8);

    logic        rd_flag;
    logic [23:0] wr_low;
    logic [31:0] busy_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_flag <= 1'b0;
            wr_low  <= '0;
        end else if (!busy && start_rd) begin
            rd_flag <= 1'b1;
        end else if (!busy && start_wr) begin
            rd_flag <= 1'b0;
            wr_low  <= wr_data[23:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                        busy_cnt <= '0;
        else if (!busy)                    busy_cnt <= '0;
        else if (busy_cnt != 32'hFFFF_FFFF) busy_cnt <= busy_cnt + 1'b1;
    end

    a_r1_idle_lines: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!sel_reg && dir_rx && !mtx));

    a_r7_tx_only_when_writing: assert property (@(posedge clk) disable iff (!rst_n)
        mtx |-> (sel_reg && !dir_rx));

    a_r3_select_after_wait: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sel_reg) |-> $past(busy));

    a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r10_done_releases: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && !sel_reg));

    a_r10_err_changes_on_done: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(err) || $fell(err)) |-> done);

    a_r6_info_byte: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !err && rd_flag) |-> (rd_result[7:0] == 8'h00 || rd_result[7:0] == 8'hFF));

    a_r5_narrow_padding: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !err && rd_flag && rd_result[7:0] == 8'h00) |->
        (rd_result[55:32] == 24'h000000 || rd_result[55:32] == 24'hFFFFFF));

    a_r8_read_low_copy: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !err && rd_flag) |-> (low_copy == rd_result[31:8]));

    a_r8_write_low_copy: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !rd_flag) |-> (low_copy == wr_low));

    a_r9_bounded_access: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (busy_cnt < BOUND));

endmodule

bind ctlreg_seq ctlreg_seq_chk #(
    .WAIT_CYC  (WAIT_CYC),
    .TOTAL_CYC (TOTAL_CYC)
) chk_i (.*);

// File: tb/ctlreg_seq_tb_top.sv
module ctlreg_seq_tb_top;

    localparam int WAIT_T   = 40;
    localparam int TOTAL_T  = 2000;
    localparam int HALF_PER = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_rd = 1'b0;
    logic        start_wr = 1'b0;
    logic [47:0] wr_data = '0;
    logic        mclk = 1'b1;
    logic        mrx = 1'b0;
    logic        mtx, sel_reg, dir_rx, busy, done, err;
    logic [55:0] rd_result;
    logic [23:0] low_copy;

    always #5 clk = ~clk;

    ctlreg_seq #(
        .WAIT_CYC    (WAIT_T),
        .TOTAL_CYC   (TOTAL_T),
        .SYNC_STAGES (2)
    ) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_rd  (start_rd),
        .start_wr  (start_wr),
        .wr_data   (wr_data),
        .mclk      (mclk),
        .mrx       (mrx),
        .mtx       (mtx),
        .sel_reg   (sel_reg),
        .dir_rx    (dir_rx),
        .busy      (busy),
        .done      (done),
        .err       (err),
        .rd_result (rd_result),
        .low_copy  (low_copy)
    );

    int n_cmp = 0;
    int n_bad = 0;

    typedef struct {
        string       tag;
        bit          is_rd;
        logic [55:0] res;
        logic        err;
        logic [23:0] low;
        logic [47:0] wbits;
    } exp_t;

    exp_t exp_q[$];

    logic [55:0] model_res = '0;
    logic [23:0] model_low = '0;

    // modem model
    logic [47:0] stream = '0;
    int          rd_idx = 0;
    logic [47:0] cap = '0;
    int          cap_n = 0;
    bit          hold_hi = 1'b0;
    int          div = 0;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] expv);
        n_cmp++;
        if (act !== expv) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    always @(negedge clk) begin
        div++;
        if (div >= HALF_PER) begin
            div = 0;
            if (!(hold_hi && mclk)) begin
                mclk = ~mclk;
                if (mclk) begin
                    if (sel_reg && dir_rx) rd_idx++;
                    if (sel_reg && !dir_rx) begin
                        cap = {cap[46:0], mtx};
                        cap_n++;
                    end
                end else begin
                    mrx = (rd_idx < 48) ? stream[47 - rd_idx] : 1'b0;
                end
            end
        end
    end

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (exp_q.size() == 0) begin
                n_cmp++;
                n_bad++;
                $display("FAIL R2 unexpected done actual=1 expected=0");
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                chk({e.tag, " R10/R9 err"}, 64'(err), 64'(e.err));
                chk({e.tag, " R5/R6 result"}, 64'(rd_result), 64'(e.res));
                chk({e.tag, " R8 low copy"}, 64'(low_copy), 64'(e.low));
                if (!e.is_rd && !e.err) begin
                    chk({e.tag, " R7 bits seen"}, 64'(cap), 64'(e.wbits));
                    chk({e.tag, " R7 bit count"}, 64'(cap_n), 64'd48);
                end
            end
        end
    end

    function automatic logic [55:0] exp_res(input logic [47:0] raw);
        if (raw[23:0] == 24'h000000 || raw[23:0] == 24'hFFFFFF)
            return {raw[23:0], raw[47:24], 8'h00};
        return {raw, 8'hFF};
    endfunction

    task automatic wait_done();
        @(negedge clk);
        while (!done) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    task automatic wait_sel();
        for (int i = 0; i < 200 && !sel_reg; i++) @(negedge clk);
    endtask

    task automatic do_read(input string tag, input logic [47:0] raw, input bit also_wr);
        exp_t e;
        model_res = exp_res(raw);
        model_low = model_res[31:8];
        e = '{tag, 1'b1, model_res, 1'b0, model_low, '0};
        exp_q.push_back(e);
        stream  = raw;
        rd_idx  = 0;
        mrx     = raw[47];
        start_rd = 1'b1;
        start_wr = also_wr;
        wr_data  = 48'hCAFE00_C0FFEE;
        @(negedge clk);
        start_rd = 1'b0;
        start_wr = 1'b0;
        wait_sel();
        chk({tag, " R4 receive direction"}, 64'(dir_rx), 64'd1);
        wait_done();
    endtask

    task automatic do_write(input string tag, input logic [47:0] val);
        exp_t e;
        model_low = val[23:0];
        e = '{tag, 1'b0, model_res, 1'b0, model_low, val};
        exp_q.push_back(e);
        cap   = '0;
        cap_n = 0;
        wr_data  = val;
        start_wr = 1'b1;
        @(negedge clk);
        start_wr = 1'b0;
        wr_data  = '0;
        wait_sel();
        chk({tag, " R7 transmit direction"}, 64'(dir_rx), 64'd0);
        wait_done();
    endtask

    bit finished = 1'b0;

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        finish_run();
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R1 reset state
        chk("R1 sel_reg", 64'(sel_reg), 64'd0);
        chk("R1 dir_rx", 64'(dir_rx), 64'd1);
        chk("R1 mtx", 64'(mtx), 64'd0);
        chk("R1 busy", 64'(busy), 64'd0);
        chk("R1 done", 64'(done), 64'd0);
        chk("R1 err", 64'(err), 64'd0);
        chk("R1 result", 64'(rd_result), 64'd0);
        chk("R1 low", 64'(low_copy), 64'd0);

        // R5 narrow register, zero padding
        do_read("R5 zero pad", 48'hA1B2C3_000000, 1'b0);
        // R5 narrow register, ones padding
        do_read("R5 ones pad", 48'h123456_FFFFFF, 1'b0);
        // R6 wide register
        do_read("R6 wide", 48'h0F1E2D_3C4B5A, 1'b0);
        // R6 near miss of the padding pattern
        do_read("R6 near miss", 48'h111111_FF00FF, 1'b0);
        do_read("R6 low FE", 48'hFFFFFF_0000FE, 1'b0);

        // R7 writes
        do_write("R7 write a", 48'hDEADBE_EF0123);
        do_write("R7 write b", 48'h800000_000001);

        // R2 both starts together: read is taken
        do_read("R2 read priority", 48'h5A5A5A_A5A5A5, 1'b1);

        // R2 start while busy is ignored
        begin
            exp_t e;
            model_res = exp_res(48'h00FF00_000000);
            model_low = model_res[31:8];
            e = '{"R2 ignore busy", 1'b1, model_res, 1'b0, model_low, '0};
            exp_q.push_back(e);
            stream = 48'h00FF00_000000;
            rd_idx = 0;
            mrx = stream[47];
            start_rd = 1'b1;
            @(negedge clk);
            start_rd = 1'b0;
            repeat (60) @(negedge clk);
            start_wr = 1'b1;
            wr_data  = 48'h123123_123123;
            @(negedge clk);
            start_wr = 1'b0;
            wr_data  = '0;
            wait_done();
            repeat (60) @(negedge clk);
            chk("R2 still idle after ignored start", 64'(busy), 64'd0);
            chk("R2 no queued item left", 64'(exp_q.size()), 64'd0);
        end

        // R3 / R9 clock held high: wait bound, then overall timeout
        hold_hi = 1'b1;
        while (!mclk) @(negedge clk);
        repeat (5) @(negedge clk);
        begin
            exp_t e;
            e = '{"R9 timeout", 1'b1, model_res, 1'b1, model_low, '0};
            exp_q.push_back(e);
            stream = 48'hFFFFFF_FFFFFF;
            rd_idx = 0;
            start_rd = 1'b1;
            @(negedge clk);
            start_rd = 1'b0;
            repeat (10) @(negedge clk);
            chk("R3 selects held during wait", 64'(sel_reg), 64'd0);
            chk("R3 busy during wait", 64'(busy), 64'd1);
            repeat (WAIT_T) @(negedge clk);
            chk("R3 proceeds after wait bound", 64'(sel_reg), 64'd1);
            wait_done();
            chk("R9 selects released", 64'(sel_reg), 64'd0);
            chk("R9 err held", 64'(err), 64'd1);
        end
        hold_hi = 1'b0;
        repeat (30) @(negedge clk);

        // R10 success clears error
        do_read("R10 recover", 48'h0A0B0C_0D0E0F, 1'b0);
        chk("R10 err cleared", 64'(err), 64'd0);
        chk("R1 idle lines after access", 64'({sel_reg, dir_rx, mtx, busy}), 64'b0100);

        repeat (10) @(negedge clk);
        finish_run();
    end

endmodule